// File: doc/BRIEF.md
# Affine-Gap Local Alignment Systolic Array

This block scores the best local alignment between a short read and a reference sequence. It uses an affine gap model. A linear chain of processing elements (PEs) evaluates the scoring matrix one anti-diagonal at a time. Each PE owns one read base, which is one row of the matrix. Reference bases travel down the chain, one column per cycle, together with a valid marker.

Each PE produces three values for each cell:
- the cell score H;
- the horizontal gap value E, which it keeps locally;
- the vertical gap value F, which it hands to the next PE together with H.

A running best score also moves down the chain, and every PE folds its own cells into it.

A read may be longer than the chain. In that case the matrix is cut into horizontal strips, each one chain height tall. The H and F values that leave the last PE are written into a boundary memory, indexed by column. On the next pass they are replayed as the top-row input of the first PE.

Both sequences are loaded serially, one base per valid cycle, while the block is idle. A go pulse starts the computation. When the final strip has drained, done rises and the best score is held for reading.

Top module: `sw_align_array`

## Requirements
- R1: Bases are 2-bit codes (A=00, C=01, G=10, T=11). With default parameters, a diagonal step scores +2 when the read base equals the reference base and −1 otherwise.
- R2: The gap model is affine. E(i,j) = max(H(i,j−1)−2, E(i,j−1)−1) and F(i,j) = max(H(i−1,j)−2, F(i−1,j)−1). H(i,j) = max(0, H(i−1,j−1)+s, E, F). All values are zero outside the matrix.
- R3: Every intermediate result below zero becomes 0. The reported score is the largest H over the whole matrix, so two sequences that share no base report 0.
- R4: Every score value is 8-bit unsigned and saturates at 255.
- R5: A read longer than the 32-PE chain is processed in ceil(read_len/32) strips. The result equals the score of the full matrix, including lengths that are not a multiple of 32.
- R6: While idle, each cycle with rd_valid (or ref_valid) high and go low appends one base to the read (or reference). Loads and go pulses made while a job is running are ignored. A go pulse empties both sequence buffers for the next job.
- R7: For a job with nonzero lengths, done first reads high after the clock edge that comes S·(ref_len+33) edges after the edge that sampled go, where S is the number of strips. done and the running state are never both active.
- R8: done and score hold their values until the next go. A go that starts a job clears done and the score to 0.
- R9: A go with an empty read or an empty reference sets done right after the edge that sampled go, and reports score 0.
- R10: After reset, done is 0 and score is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read base strobe |
| rd_base | input | 2 | Read base code |
| ref_valid | input | 1 | Reference base strobe |
| ref_base | input | 2 | Reference base code |
| go | input | 1 | Start pulse; also empties both load buffers |
| done | output | 1 | Result valid, held until the next go |
| score | output | 8 | Best local alignment score |

## Verification
Internal state only reaches the ports through the final score and the time at which done rises, so faults show up only when a job ends.
- A corrupted E or diagonal register changes the score only when the sequences involve gaps or shifted matches. The bench therefore uses hand-built gap cases as well as pseudo-random pairs checked against a software model of the full matrix.
- A fault in the boundary memory or the strip sequencing appears only for reads longer than 32 bases, either as a wrong score or as a done that comes at the wrong cycle.
- A wrong strip count shifts done by ref_len+33 cycles per strip, so each job also checks the exact latency.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef logic [1:0] base_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/sw_sram.sv
module sw_sram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sw_pe.sv
module sw_pe import sw_pkg::*; #(
  parameter int W        = 8,
  parameter int MATCH    = 2,
  parameter int MISMATCH = 1,
  parameter int GOPEN    = 2,
  parameter int GEXT     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  base_t        row_base,
  input  logic         row_act,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  base_t        in_base,
  input  logic [W-1:0] in_h,
  input  logic [W-1:0] in_f,
  input  logic [W-1:0] in_max,
  output logic         out_valid,
  output logic         out_first,
  output logic         out_last,
  output base_t        out_base,
  output logic [W-1:0] out_h,
  output logic [W-1:0] out_f,
  output logic [W-1:0] out_max
);
  localparam int SMAX = (1 << W) - 1;

  function automatic logic [W-1:0] sub0(logic [W-1:0] a, int b);
    int t;
    t = int'(a) - b;
    return (t < 0) ? '0 : W'(t);
  endfunction

  function automatic logic [W-1:0] addsat(logic [W-1:0] a, int b);
    int t;
    t = int'(a) + b;
    return (t > SMAX) ? W'(SMAX) : W'(t);
  endfunction

  function automatic logic [W-1:0] max2(logic [W-1:0] a, logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [W-1:0] e_q, d_q;
  logic [W-1:0] e_d, h_d, f_d, max_d;
  logic [W-1:0] left_h, left_e, diag_h, diag_s, prev_max;

  always_comb begin
    left_h   = in_first ? '0 : out_h;
    left_e   = in_first ? '0 : e_q;
    diag_h   = in_first ? '0 : d_q;
    prev_max = in_first ? '0 : out_max;
    diag_s   = (row_base == in_base) ? addsat(diag_h, MATCH) : sub0(diag_h, MISMATCH);
    e_d      = max2(sub0(left_h, GOPEN), sub0(left_e, GEXT));
    f_d      = max2(sub0(in_h, GOPEN), sub0(in_f, GEXT));
    h_d      = max2(diag_s, max2(e_d, f_d));
    if (!row_act) begin
      e_d = '0;
      f_d = '0;
      h_d = '0;
    end
    max_d = max2(in_max, max2(h_d, prev_max));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_base  <= '0;
      out_h     <= '0;
      out_f     <= '0;
      out_max   <= '0;
      e_q       <= '0;
      d_q       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_first <= in_first;
        out_last  <= in_last;
        out_base  <= in_base;
        out_h     <= h_d;
        out_f     <= f_d;
        out_max   <= max_d;
        e_q       <= e_d;
        d_q       <= in_h;
      end
    end
  end
endmodule

// File: rtl/sw_align_array.sv
module sw_align_array import sw_pkg::*; #(
  parameter int N_PE     = 32,
  parameter int SCORE_W  = 8,
  parameter int MAX_READ = 128,
  parameter int MAX_REF  = 1024,
  parameter int MATCH    = 2,
  parameter int MISMATCH = 1,
  parameter int GAP_OPEN = 2,
  parameter int GAP_EXT  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  input  logic [1:0]         rd_base,
  input  logic               ref_valid,
  input  logic [1:0]         ref_base,
  input  logic               go,
  output logic               done,
  output logic [SCORE_W-1:0] score
);
  localparam int RD_AW = $clog2(MAX_READ);
  localparam int RF_AW = $clog2(MAX_REF);
  localparam int RD_CW = RD_AW + 1;
  localparam int RF_CW = RF_AW + 1;
  localparam int BND_W = 2 * SCORE_W;

  logic rst_ni;
  sw_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ni));

  seq_state_e         state_q, state_d;
  logic [RF_CW-1:0]   col_q, col_d, n_ref_q, n_ref_d, rf_cnt_q, rf_cnt_d;
  logic [RD_CW-1:0]   strip_q, strip_d, n_rd_q, n_rd_d, rd_cnt_q, rd_cnt_d;
  logic [SCORE_W-1:0] best_q, best_d;
  logic               done_q, done_d;
  logic [RF_AW-1:0]   wr_col_q;
  logic               busy;

  logic [N_PE:0]      c_valid, c_first, c_last;
  base_t              c_base [N_PE+1];
  logic [SCORE_W-1:0] c_h [N_PE+1];
  logic [SCORE_W-1:0] c_f [N_PE+1];
  logic [SCORE_W-1:0] c_max [N_PE+1];

  logic               tail_valid, tail_first, tail_last;
  logic [SCORE_W-1:0] tail_h, tail_f, tail_max;

  assign tail_valid = c_valid[N_PE];
  assign tail_first = c_first[N_PE];
  assign tail_last  = c_last[N_PE];
  assign tail_h     = c_h[N_PE];
  assign tail_f     = c_f[N_PE];
  assign tail_max   = c_max[N_PE];
  assign busy       = (state_q != ST_IDLE);

  logic idle_load;
  logic rd_we, rf_we;
  assign idle_load = (state_q == ST_IDLE) && !go;
  assign rd_we = rd_valid && idle_load && (rd_cnt_q < RD_CW'(MAX_READ));
  assign rf_we = ref_valid && idle_load && (rf_cnt_q < RF_CW'(MAX_REF));

  base_t rd_buf [MAX_READ];
  always_ff @(posedge clk) begin
    if (rd_we) rd_buf[rd_cnt_q[RD_AW-1:0]] <= rd_base;
  end

  logic feed_en;
  base_t ref_rdata;
  assign feed_en = (state_q == ST_FEED);

  sw_sram #(.DEPTH(MAX_REF), .WIDTH(2)) u_ref_mem (
    .clk(clk), .we(rf_we), .waddr(rf_cnt_q[RF_AW-1:0]), .wdata(ref_base),
    .re(feed_en), .raddr(col_q[RF_AW-1:0]), .rdata(ref_rdata)
  );

  logic             bnd_we;
  logic [RF_AW-1:0] bnd_waddr;
  logic [BND_W-1:0] bnd_rdata;
  assign bnd_we    = tail_valid;
  assign bnd_waddr = tail_first ? '0 : wr_col_q;

  sw_sram #(.DEPTH(MAX_REF), .WIDTH(BND_W)) u_bnd_mem (
    .clk(clk), .we(bnd_we), .waddr(bnd_waddr), .wdata({tail_h, tail_f}),
    .re(feed_en), .raddr(col_q[RF_AW-1:0]), .rdata(bnd_rdata)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wr_col_q <= '0;
    else if (tail_valid) wr_col_q <= bnd_waddr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      c_valid[0] <= 1'b0;
      c_first[0] <= 1'b0;
      c_last[0]  <= 1'b0;
    end else begin
      c_valid[0] <= feed_en;
      if (feed_en) begin
        c_first[0] <= (col_q == '0);
        c_last[0]  <= (col_q == n_ref_q - 1'b1);
      end
    end
  end

  assign c_base[0] = ref_rdata;
  assign c_h[0]    = (strip_q == '0) ? '0 : bnd_rdata[BND_W-1:SCORE_W];
  assign c_f[0]    = (strip_q == '0) ? '0 : bnd_rdata[SCORE_W-1:0];
  assign c_max[0]  = '0;

  for (genvar k = 0; k < N_PE; k++) begin : g_pe
    int    row_i;
    logic  act;
    base_t rb;
    always_comb begin
      row_i = int'(strip_q) + k;
      act   = row_i < int'(n_rd_q);
      rb    = rd_buf[row_i[RD_AW-1:0]];
    end

    sw_pe #(.W(SCORE_W), .MATCH(MATCH), .MISMATCH(MISMATCH),
            .GOPEN(GAP_OPEN), .GEXT(GAP_EXT)) u_pe (
      .clk(clk), .rst_n(rst_ni), .row_base(rb), .row_act(act),
      .in_valid(c_valid[k]), .in_first(c_first[k]), .in_last(c_last[k]),
      .in_base(c_base[k]), .in_h(c_h[k]), .in_f(c_f[k]), .in_max(c_max[k]),
      .out_valid(c_valid[k+1]), .out_first(c_first[k+1]), .out_last(c_last[k+1]),
      .out_base(c_base[k+1]), .out_h(c_h[k+1]), .out_f(c_f[k+1]), .out_max(c_max[k+1])
    );
  end

  always_comb begin
    state_d  = state_q;
    col_d    = col_q;
    strip_d  = strip_q;
    n_rd_d   = n_rd_q;
    n_ref_d  = n_ref_q;
    rd_cnt_d = rd_we ? rd_cnt_q + 1'b1 : rd_cnt_q;
    rf_cnt_d = rf_we ? rf_cnt_q + 1'b1 : rf_cnt_q;
    best_d   = best_q;
    done_d   = done_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          n_rd_d   = rd_cnt_q;
          n_ref_d  = rf_cnt_q;
          rd_cnt_d = '0;
          rf_cnt_d = '0;
          best_d   = '0;
          strip_d  = '0;
          col_d    = '0;
          if (rd_cnt_q == '0 || rf_cnt_q == '0) begin
            done_d = 1'b1;
          end else begin
            done_d  = 1'b0;
            state_d = ST_FEED;
          end
        end
      end
      ST_FEED: begin
        col_d = col_q + 1'b1;
        if (col_q == n_ref_q - 1'b1) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (tail_valid && tail_last) begin
          best_d = (tail_max > best_q) ? tail_max : best_q;
          if (int'(strip_q) + N_PE < int'(n_rd_q)) begin
            strip_d = strip_q + RD_CW'(N_PE);
            col_d   = '0;
            state_d = ST_FEED;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      col_q    <= '0;
      strip_q  <= '0;
      n_rd_q   <= '0;
      n_ref_q  <= '0;
      rd_cnt_q <= '0;
      rf_cnt_q <= '0;
      best_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      col_q    <= col_d;
      strip_q  <= strip_d;
      n_rd_q   <= n_rd_d;
      n_ref_q  <= n_ref_d;
      rd_cnt_q <= rd_cnt_d;
      rf_cnt_q <= rf_cnt_d;
      best_q   <= best_d;
      done_q   <= done_d;
    end
  end

  assign done  = done_q;
  assign score = best_q;
endmodule

// File: rtl/sw_align_array_chk.sv
module sw_align_array_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic         done,
  input logic         busy,
  input logic [W-1:0] score,
  input logic         tail_valid,
  input logic         tail_first,
  input logic [W-1:0] tail_h,
  input logic [W-1:0] tail_max
);
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && $stable(score)));

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && score == '0));

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  assert_run_max_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_valid && !tail_first && $past(tail_valid)) |-> (tail_max >= $past(tail_max)));

  assert_cell_le_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tail_valid |-> (tail_h <= tail_max));
endmodule

bind sw_align_array sw_align_array_chk #(.W(SCORE_W)) u_chk (
  .clk(clk), .rst_n(rst_ni), .go(go), .done(done), .busy(busy), .score(score),
  .tail_valid(tail_valid), .tail_first(tail_first), .tail_h(tail_h), .tail_max(tail_max)
);

// File: tb/sw_align_array_bench.sv
module sw_align_array_bench;
  logic       clk;
  logic       rst_n;
  logic       rd_valid, ref_valid, go;
  logic [1:0] rd_base, ref_base;
  logic       done;
  logic [7:0] score;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [1:0] rd_m [128];
  logic [1:0] rf_m [256];
  int         hp [257];
  int         fp [257];
  int         hc [257];
  int         fc [257];
  int         lcg = 12345;

  sw_align_array u_sw_align_array (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_base(rd_base),
    .ref_valid(ref_valid), .ref_base(ref_base), .go(go), .done(done), .score(score)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sub0(int a, int b);
    return (a - b < 0) ? 0 : a - b;
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int model(int nr, int nf);
    int best = 0;
    for (int j = 0; j <= nf; j++) begin
      hp[j] = 0;
      fp[j] = 0;
    end
    for (int i = 1; i <= nr; i++) begin
      int e = 0;
      hc[0] = 0;
      for (int j = 1; j <= nf; j++) begin
        int s, f, h;
        e = mx(sub0(hc[j-1], 2), sub0(e, 1));
        f = mx(sub0(hp[j], 2), sub0(fp[j], 1));
        s = (rd_m[i-1] == rf_m[j-1]) ? hp[j-1] + 2 : sub0(hp[j-1], 1);
        if (s > 255) s = 255;
        h = mx(s, mx(e, f));
        hc[j] = h;
        fc[j] = f;
        best = mx(best, h);
      end
      for (int j = 0; j <= nf; j++) begin
        hp[j] = hc[j];
        fp[j] = fc[j];
      end
    end
    return best;
  endfunction

  function automatic logic [1:0] rnd();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg[17:16];
  endfunction

  task automatic load(input int nr, input int nf);
    for (int i = 0; i < nr; i++) begin
      @(negedge clk);
      rd_valid = 1'b1;
      rd_base  = rd_m[i];
    end
    @(negedge clk);
    rd_valid = 1'b0;
    for (int j = 0; j < nf; j++) begin
      @(negedge clk);
      ref_valid = 1'b1;
      ref_base  = rf_m[j];
    end
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic run(input bit inject, output int lat);
    @(negedge clk);
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go  = 1'b0;
    lat = 0;
    while (!done && lat < 5000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (inject) begin
        rd_valid  = (lat >= 5 && lat < 9);
        ref_valid = (lat >= 5 && lat < 9);
        go        = (lat >= 5 && lat < 9);
        rd_base   = 2'b11;
        ref_base  = 2'b10;
      end
    end
    rd_valid  = 1'b0;
    ref_valid = 1'b0;
    go        = 1'b0;
  endtask

  task automatic job(input int nr, input int nf, input string req, input int hand);
    int lat, exp_s, exp_lat;
    exp_s   = model(nr, nf);
    exp_lat = ((nr + 31) / 32) * (nf + 33);
    load(nr, nf);
    run(1'b0, lat);
    check(score == 8'(exp_s), req, score, exp_s);
    if (hand >= 0) check(exp_s == hand && score == 8'(hand), req, score, hand);
    check(lat == exp_lat, "R7 done latency", lat, exp_lat);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R10 done after reset", done, 0);
    check(score == 8'd0, "R10 score after reset", score, 0);
  endtask

  task automatic t_exact();
    logic [1:0] s [8] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
    for (int i = 0; i < 8; i++) begin
      rd_m[i] = s[i];
      rf_m[i] = s[i];
    end
    job(8, 8, "R1 exact match", 16);
  endtask

  task automatic t_nomatch();
    for (int i = 0; i < 4; i++) begin
      rd_m[i] = 2'd0;
      rf_m[i] = 2'd1;
    end
    job(4, 4, "R3 disjoint sequences", 0);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 8; i++) rd_m[i] = (i < 4) ? 2'd0 : 2'd1;
    for (int j = 0; j < 9; j++) rf_m[j] = (j < 4) ? 2'd0 : (j == 4) ? 2'd2 : 2'd1;
    job(8, 9, "R2 single gap open", 14);
    for (int j = 0; j < 10; j++) rf_m[j] = (j < 4) ? 2'd0 : (j < 6) ? 2'd2 : 2'd1;
    job(8, 10, "R2 gap extend", 13);
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) rd_m[i] = rnd();
    for (int j = 0; j < 40; j++) rf_m[j] = rnd();
    for (int i = 0; i < 12; i++) rf_m[10 + i] = rd_m[3 + i];
    job(20, 40, "R1 R2 random pair", -1);
  endtask

  task automatic t_strips();
    for (int i = 0; i < 70; i++) rd_m[i] = rnd();
    for (int j = 0; j < 50; j++) rf_m[j] = rnd();
    for (int i = 0; i < 30; i++) rf_m[15 + i] = rd_m[25 + i];
    job(70, 50, "R5 three strips", -1);
    for (int i = 0; i < 33; i++) begin
      rd_m[i] = rnd();
      rf_m[i] = rd_m[i];
    end
    job(33, 33, "R5 strip boundary 33", 66);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 128; i++) rd_m[i] = 2'd0;
    for (int j = 0; j < 140; j++) rf_m[j] = 2'd0;
    job(128, 140, "R4 saturation", 255);
  endtask

  task automatic t_empty();
    int lat;
    run(1'b0, lat);
    check(done == 1'b1 && lat == 0, "R9 empty job latency", lat, 0);
    check(score == 8'd0, "R9 empty job score", score, 0);
  endtask

  task automatic t_busy_ignore();
    int lat, exp_s;
    for (int i = 0; i < 10; i++) rd_m[i] = rnd();
    for (int j = 0; j < 20; j++) rf_m[j] = rnd();
    for (int i = 0; i < 6; i++) rf_m[7 + i] = rd_m[2 + i];
    exp_s = model(10, 20);
    load(10, 20);
    run(1'b1, lat);
    check(score == 8'(exp_s), "R6 loads during job ignored", score, exp_s);
    check(lat == 53, "R6 go during job ignored", lat, 53);
    run(1'b0, lat);
    check(lat == 0 && score == 8'd0, "R6 buffers emptied by go", score, 0);
  endtask

  task automatic t_hold();
    logic [7:0] s0;
    s0 = score;
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R8 done holds", done, 1);
    check(score == s0, "R8 score holds", score, s0);
  endtask

  initial begin
    rst_n = 1'b0;
    rd_valid = 1'b0;
    ref_valid = 1'b0;
    go = 1'b0;
    rd_base = '0;
    ref_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_exact();
    t_hold();
    t_nomatch();
    t_gaps();
    t_random();
    t_strips();
    t_saturate();
    t_hold();
    t_empty();
    t_busy_ignore();
    finish_run();
  end
endmodule